// File: doc/BRIEF.md
# Conversion Start Synchronizer

This block decides when a successive-approximation conversion begins and when a running one is thrown away. Two requests can start a conversion. One is an external convert pin that is not synchronous to anything. The other is a one-bit start request from the register side. Both are timed against a slow conversion clock, which is the data clock divided by a power of two chosen at run time. That slow clock appears inside the data-clock domain as a one-cycle tick, and every timing rule below is counted in those ticks.

A pin request is accepted only if the pin was low for long enough before it rose and stays high for long enough after. It takes effect on the second tick after the edge is recognised. If a conversion is running at that moment, the pin request abandons it and starts a new one. A register request waits for the same two ticks but never interrupts anything: while a conversion is running, or while another start is pending, it is dropped.

The analog converter is replaced by a counter. It samples the input word at the start, runs for twelve ticks, then pulses done for one cycle and loads the sampled word into the result register. A flag records whether the last start came from the pin or from the register request, so that read-back logic downstream can tell the two apart.

Top module: `conv_start_sync`

## Requirements
- R1: `cconv_tick` is high for one data-clock cycle out of every 2^`div_sel` cycles, so it is high on every cycle when `div_sel` is 0.
- R2: `conv_pin` passes through a two-flop synchronizer. Its rise is recognised on the third cycle after the pin is driven high, and `conv_start` pulses in the cycle of the second `cconv_tick` that follows the recognition cycle.
- R3: A `reg_start` that is sampled high and accepted produces `conv_start` in the cycle of the second `cconv_tick` after the clock edge that sampled it.
- R4: A pin rise is ignored unless the synchronized pin was low for at least two `cconv_tick` cycles before it rose.
- R5: A pending pin start is dropped if the synchronized pin goes low before the second tick after its rise.
- R6: `busy` rises in the cycle after `conv_start` and stays high until the conversion ends.
- R7: `conv_done` pulses for one cycle on the twelfth tick after the start. In the next cycle `busy` is low and `result` holds the value `ain` had in the start cycle. Apart from that, `result` does not change.
- R8: A pin start while `busy` is high raises `conv_abort` with `conv_start`, keeps `busy` high, suppresses the done of the old conversion, and times a fresh twelve-tick conversion.
- R9: A `reg_start` sampled while `busy` is high, or while a start is already pending, is discarded and never produces a start later.
- R10: `start_from_pin` is 1 after a pin start and 0 after a register start, and is updated with each `conv_start`.
- R11: After reset, `busy`, `conv_start`, `conv_abort`, `conv_done`, `start_from_pin` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Conversion clock ratio: 2^div_sel data clocks |
| conv_pin | input | 1 | Asynchronous external convert request |
| reg_start | input | 1 | Register-side start request, data-clock domain |
| ain | input | 12 | Stand-in analog value sampled at start |
| cconv_tick | output | 1 | One-cycle conversion-clock falling-edge tick |
| conv_start | output | 1 | Conversion start strobe |
| conv_abort | output | 1 | Strobe that a running conversion was restarted |
| busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 12 | Last completed conversion result |
| start_from_pin | output | 1 | Source of the last start: 1 pin, 0 register |

## Verification
The properties assume that `div_sel` changes only while no conversion is running and no start is pending. The stimulus therefore writes it only during idle gaps. The properties also assume that `reg_start` is a data-clock-domain signal. The bench drives it and the pin on falling clock edges, and holds the pin low for many tick periods before each request that should be accepted. Because of this, every rejected pin request is rejected for exactly the width rule under test.

// File: rtl/conv_sync_pkg.sv
package conv_sync_pkg;
  localparam int DEF_SEL_W       = 2;
  localparam int DEF_RES_W       = 12;
  localparam int DEF_CONV_TICKS  = 12;
  localparam int DEF_START_TICKS = 2;
  localparam int DEF_LOW_TICKS   = 2;
  localparam int DEF_SYNC        = 2;

  typedef enum logic {
    SRC_REG = 1'b0,
    SRC_PIN = 1'b1
  } start_src_e;
endpackage

// File: rtl/cclk_div.sv
module cclk_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int CW = (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = CW'((1 << div_sel) - 1);
    tick  = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pin_qual.sv
module pin_qual #(
  parameter int SYNC        = 2,
  parameter int LOW_TICKS   = 2,
  parameter int START_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic tick,
  output logic armed,
  output logic go
);
  localparam int LW = $clog2(LOW_TICKS + 1);
  localparam int HW = $clog2(START_TICKS + 1);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [LW-1:0]   low_q, low_d;
  logic            pend_q, pend_d;
  logic [HW-1:0]   hcnt_q, hcnt_d;
  logic            lvl, rise, low_ok;

  always_comb begin
    lvl    = sync_q[SYNC-1];
    rise   = lvl & ~prev_q;
    low_ok = (low_q == LW'(LOW_TICKS));
    go     = pend_q & lvl & tick & (hcnt_q == HW'(START_TICKS - 1));
    armed  = pend_q;

    low_d = low_q;
    if (lvl)                 low_d = '0;
    else if (tick && !low_ok) low_d = low_q + 1'b1;

    pend_d = pend_q;
    hcnt_d = hcnt_q;
    if (rise) begin
      pend_d = low_ok;
      hcnt_d = '0;
    end else if (pend_q) begin
      if (!lvl || go) pend_d = 1'b0;
      else if (tick)  hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      low_q  <= '0;
      pend_q <= 1'b0;
      hcnt_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_async};
      prev_q <= lvl;
      low_q  <= low_d;
      pend_q <= pend_d;
      hcnt_q <= hcnt_d;
    end
  end
endmodule

// File: rtl/reg_req.sv
module reg_req #(
  parameter int START_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic accept_ok,
  input  logic tick,
  input  logic cancel,
  output logic go
);
  localparam int HW = $clog2(START_TICKS + 1);

  logic          pend_q, pend_d;
  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    go     = pend_q & tick & (cnt_q == HW'(START_TICKS - 1));
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (pend_q) begin
      if (go || cancel) pend_d = 1'b0;
      else if (tick)    cnt_d  = cnt_q + 1'b1;
    end else if (req && accept_ok) begin
      pend_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int RES_W      = 12,
  parameter int CONV_TICKS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  logic [RES_W-1:0] ain,
  output logic             active,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int CW = $clog2(CONV_TICKS);

  logic             act_q, act_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RES_W-1:0] samp_q, res_q;

  always_comb begin
    done  = act_q & tick & (cnt_q == CW'(CONV_TICKS - 1)) & ~go;
    act_d = act_q;
    cnt_d = cnt_q;
    if (go) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (done) begin
      act_d = 1'b0;
    end else if (act_q && tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      samp_q <= '0;
      res_q  <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      if (go)   samp_q <= ain;
      if (done) res_q  <= samp_q;
    end
  end

  assign active = act_q;
  assign result = res_q;
endmodule

// File: rtl/conv_start_sync.sv
module conv_start_sync
  import conv_sync_pkg::*;
#(
  parameter int SEL_W       = DEF_SEL_W,
  parameter int RES_W       = DEF_RES_W,
  parameter int CONV_TICKS  = DEF_CONV_TICKS,
  parameter int START_TICKS = DEF_START_TICKS,
  parameter int LOW_TICKS   = DEF_LOW_TICKS,
  parameter int SYNC        = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             conv_pin,
  input  logic             reg_start,
  input  logic [RES_W-1:0] ain,
  output logic             cconv_tick,
  output logic             conv_start,
  output logic             conv_abort,
  output logic             busy,
  output logic             conv_done,
  output logic [RES_W-1:0] result,
  output logic             start_from_pin
);
  logic [1:0]  rsync_q;
  logic        rst_core_n;
  logic        tick, pin_armed, pin_go, reg_go, active;
  start_src_e  src_q, src_d;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  cclk_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_core_n), .div_sel(div_sel), .tick(tick)
  );

  pin_qual #(.SYNC(SYNC), .LOW_TICKS(LOW_TICKS), .START_TICKS(START_TICKS)) u_pin (
    .clk(clk), .rst_n(rst_core_n), .pin_async(conv_pin), .tick(tick),
    .armed(pin_armed), .go(pin_go)
  );

  reg_req #(.START_TICKS(START_TICKS)) u_reg (
    .clk(clk), .rst_n(rst_core_n), .req(reg_start),
    .accept_ok(~active & ~pin_armed), .tick(tick), .cancel(pin_go), .go(reg_go)
  );

  conv_seq #(.RES_W(RES_W), .CONV_TICKS(CONV_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .go(pin_go | reg_go), .ain(ain),
    .active(active), .done(conv_done), .result(result)
  );

  always_comb begin
    src_d = src_q;
    if (pin_go)      src_d = SRC_PIN;
    else if (reg_go) src_d = SRC_REG;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) src_q <= SRC_REG;
    else             src_q <= src_d;
  end

  assign cconv_tick     = tick;
  assign conv_start     = pin_go | reg_go;
  assign conv_abort     = pin_go & active;
  assign busy           = active;
  assign start_from_pin = (src_q == SRC_PIN);
endmodule

// File: rtl/conv_sync_chk.sv
module conv_sync_chk #(
  parameter int SEL_W = 2,
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] div_sel,
  input logic             cconv_tick,
  input logic             conv_start,
  input logic             conv_abort,
  input logic             busy,
  input logic             conv_done,
  input logic [RES_W-1:0] result,
  input logic             start_from_pin
);
  // R1
  tick_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0) |-> cconv_tick);

  // R2 R3
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> cconv_tick);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy);

  // R7
  done_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (busy && !conv_start));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !busy);

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result));

  // R8
  abort_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> (conv_start && busy));

  // R9 R10
  busy_start_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && busy) |=> start_from_pin);
endmodule

bind conv_start_sync conv_sync_chk #(.SEL_W(SEL_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cconv_tick(cconv_tick),
  .conv_start(conv_start), .conv_abort(conv_abort), .busy(busy),
  .conv_done(conv_done), .result(result), .start_from_pin(start_from_pin)
);

// File: tb/sim_conv_start_sync.sv
module sim_conv_start_sync;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  div_sel;
  logic        conv_pin;
  logic        reg_start;
  logic [11:0] ain;
  logic        cconv_tick, conv_start, conv_abort, busy, conv_done, start_from_pin;
  logic [11:0] result;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  conv_start_sync u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .conv_pin(conv_pin),
    .reg_start(reg_start), .ain(ain), .cconv_tick(cconv_tick),
    .conv_start(conv_start), .conv_abort(conv_abort), .busy(busy),
    .conv_done(conv_done), .result(result), .start_from_pin(start_from_pin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pin_low(input int n);
    conv_pin = 1'b0;
    repeat (n) step();
  endtask

  task automatic watch_no_start(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (conv_start) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  // waits for the start strobe; leaves the bench at the cycle after it
  task automatic wait_start(input int pre, input bit exp_abort, input bit exp_pin,
                            input string req);
    int nt = 0;
    bit seen = 0;
    int bad_done = 0;
    repeat (pre) step();
    for (int i = 0; i < 400 && !seen; i++) begin
      step();
      reg_start = 1'b0;
      if (conv_done) bad_done++;
      if (cconv_tick) nt++;
      if (conv_start) begin
        seen = 1;
        chk(nt == 2, req, nt, 2);
        chk(conv_abort == exp_abort, "R8 abort strobe", int'(conv_abort), int'(exp_abort));
      end
    end
    chk(seen, req, int'(seen), 1);
    chk(bad_done == 0, "R8 no stale done", bad_done, 0);
    step();
    chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    chk(start_from_pin == exp_pin, "R10 start source", int'(start_from_pin), int'(exp_pin));
  endtask

  task automatic finish_conv(input logic [11:0] val, input int poke);
    int nt = 0;
    bit seen = 0;
    int low_busy = 0;
    ain = ~val;
    for (int i = 0; i < 800 && !seen; i++) begin
      if (i > 0) step();
      reg_start = (i == poke);
      if (cconv_tick) nt++;
      if (!busy) low_busy++;
      if (conv_done) begin
        seen = 1;
        chk(nt == 12, "R7 done tick", nt, 12);
      end
    end
    reg_start = 1'b0;
    chk(seen, "R7 done seen", int'(seen), 1);
    chk(low_busy == 0, "R6 busy held", low_busy, 0);
    step();
    chk(busy == 1'b0, "R7 busy falls", int'(busy), 0);
    chk(result == val, "R7 result", int'(result), int'(val));
  endtask

  task automatic t_reset();
    chk(busy == 0 && conv_start == 0 && conv_abort == 0 && conv_done == 0,
        "R11 idle strobes", int'({busy, conv_start, conv_abort, conv_done}), 0);
    chk(result == 12'd0, "R11 result", int'(result), 0);
    chk(start_from_pin == 0, "R11 source", int'(start_from_pin), 0);
  endtask

  task automatic t_div(input logic [1:0] sel);
    int gap = 0;
    div_sel = sel;
    repeat (10) step();
    while (!cconv_tick) step();
    step();
    gap = 1;
    while (!cconv_tick) begin
      step();
      gap++;
    end
    chk(gap == (1 << sel), "R1 tick spacing", gap, 1 << sel);
  endtask

  task automatic t_reg(input logic [1:0] sel, input logic [11:0] val);
    div_sel = sel;
    pin_low(20);
    ain = val;
    reg_start = 1'b1;
    wait_start(0, 1'b0, 1'b0, "R3 register start tick");
    finish_conv(val, -1);
  endtask

  task automatic t_pin(input logic [1:0] sel, input logic [11:0] val);
    div_sel = sel;
    pin_low(40);
    ain = val;
    conv_pin = 1'b1;
    wait_start(2, 1'b0, 1'b1, "R2 pin start tick");
    finish_conv(val, -1);
    pin_low(40);
  endtask

  task automatic t_short_high();
    div_sel = 2'd2;
    pin_low(40);
    conv_pin = 1'b1;
    step();
    step();
    conv_pin = 1'b0;
    watch_no_start(60, "R5 short high ignored");
  endtask

  task automatic t_short_low();
    div_sel = 2'd2;
    pin_low(40);
    ain = 12'h5A3;
    conv_pin = 1'b1;
    wait_start(2, 1'b0, 1'b1, "R2 pin start tick");
    finish_conv(12'h5A3, -1);
    conv_pin = 1'b0;
    step();
    step();
    conv_pin = 1'b1;
    watch_no_start(80, "R4 short low ignored");
    pin_low(40);
  endtask

  task automatic t_abort();
    int bad = 0;
    div_sel = 2'd2;
    pin_low(40);
    ain = 12'h111;
    reg_start = 1'b1;
    wait_start(0, 1'b0, 1'b0, "R3 register start tick");
    for (int i = 0; i < 10; i++) begin
      step();
      if (!busy || conv_done) bad++;
    end
    chk(bad == 0, "R8 first conversion running", bad, 0);
    ain = 12'hC3C;
    conv_pin = 1'b1;
    wait_start(2, 1'b1, 1'b1, "R8 pin restart tick");
    finish_conv(12'hC3C, -1);
    pin_low(40);
  endtask

  task automatic t_reg_ignored();
    div_sel = 2'd2;
    pin_low(20);
    ain = 12'h0F0;
    reg_start = 1'b1;
    wait_start(0, 1'b0, 1'b0, "R3 register start tick");
    finish_conv(12'h0F0, 5);
    watch_no_start(60, "R9 register start while busy dropped");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    div_sel = 2'd2;
    conv_pin = 1'b0;
    reg_start = 1'b0;
    ain = 12'h000;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    for (int s = 0; s < 4; s++) t_div(2'(s));
    t_reg(2'd2, 12'hABC);
    t_reg(2'd0, 12'h123);
    t_pin(2'd2, 12'h7E1);
    t_pin(2'd3, 12'h804);
    t_pin(2'd0, 12'hFFF);
    t_short_high();
    t_short_low();
    t_abort();
    t_reg_ignored();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule